// File: doc/BRIEF.md
# Barrel Shifter with Condition Flag Update

This block is the shift stage of a small processor datapath. It moves a 32-bit operand by a variable number of places. Four kinds of move are supported: arithmetic right, logical left, logical right and rotate right. It returns the shifted value and a new set of condition flags. The negative and zero flags always follow the result. The carry flag takes the last bit that moved out of the operand, and keeps its old value when nothing moves. The overflow flag passes through untouched.

The shift length comes from one of two places. The first is a 5-bit immediate field. The second is the low byte of a second register operand, so it can range from 0 to 255. A register-sourced length can run past the word width, and the unit gives defined results in that case for every kind of move. The outputs are registered by default, which gives one cycle of latency. A parameter removes the register and makes the unit purely combinational. Instruction decode and the register file sit outside this block.

Top module: `shifter_unit`

## Requirements
- R1: `op_i` selects the move: 0 = arithmetic right, 1 = logical left, 2 = logical right, 3 = rotate right. With the default output register, the result and flags for the inputs present at a rising clock edge appear on the outputs just after that edge.
- R2: When `src_reg_i` is 0, the length is `imm_i`. An `imm_i` of 0 means 32 for arithmetic right and logical right, and means 0 for logical left and rotate right. Any other value is used as it stands.
- R3: When `src_reg_i` is 1, the length is `rs_i[7:0]`. Bits `rs_i[31:8]` have no effect.
- R4: `flags_o[3]` (N) equals bit 31 of the result, and `flags_o[2]` (Z) is 1 exactly when the result is zero.
- R5: `flags_o[0]` (V) always equals the incoming `flags_i[0]`.
- R6: A length of 0, from either source and for any move, returns the operand unchanged and copies `flags_i[1]` to C. A logical left move by an immediate 0 therefore acts as a plain move.
- R7: For lengths 1 to 31, C is the last bit moved out. That is operand bit 32-n for a left move and operand bit n-1 for a right move or a rotation.
- R8: A logical move by exactly 32 gives a zero result. C is then operand bit 0 for a left move and operand bit 31 for a right move.
- R9: A logical move by more than 32 gives a zero result and clears C.
- R10: An arithmetic right move by 32 or more fills every result bit and C with operand bit 31.
- R11: A rotation uses the length modulo 32, and C equals result bit 31. A nonzero multiple of 32 returns the operand unchanged and sets C to operand bit 31.
- R12: While `rst_n` is low, `res_o` and `flags_o` are held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| opd_i | input | 32 | Operand to be shifted |
| imm_i | input | 5 | Immediate shift length field |
| rs_i | input | 32 | Register whose low byte supplies the length |
| src_reg_i | input | 1 | Length source: 0 = immediate, 1 = register |
| op_i | input | 2 | Move kind select |
| flags_i | input | 4 | Incoming flags {N, Z, C, V} |
| res_o | output | 32 | Shifted result |
| flags_o | output | 4 | Updated flags {N, Z, C, V} |

## Verification
The unit holds no state across operations beyond the output register. A wrong internal decision, such as a badly saturated length, the wrong carry tap or a missed zero-length case, shows up in `res_o` or `flags_o[1]` in the cycle right after the faulty inputs are applied. The length boundaries 0, 1, 31, 32, 33 and 255 are the places where a saturation or modulo mistake first appears, so they are hit directly for every move kind. Random stimulus over both length sources covers the rest.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        MV_ASR = 2'd0,
        MV_LSL = 2'd1,
        MV_LSR = 2'd2,
        MV_ROR = 2'd3
    } shf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } shf_flags_t;
endpackage

// File: rtl/shf_amount.sv
module shf_amount
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = $clog2(W),
    parameter int AW = 8
) (
    input  logic [IW-1:0] imm_i,
    input  logic [W-1:0]  rs_i,
    input  logic          src_reg_i,
    input  shf_op_e       op_i,
    output logic [AW-1:0] amt_o
);
    localparam logic [AW-1:0] FULL = AW'(W);

    always_comb begin
        if (src_reg_i) begin
            amt_o = rs_i[AW-1:0];
        end else if (imm_i == '0 && (op_i == MV_ASR || op_i == MV_LSR)) begin
            amt_o = FULL;
        end else begin
            amt_o = AW'(imm_i);
        end
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  opd_i,
    input  logic [AW-1:0] amt_i,
    input  shf_op_e       op_i,
    input  logic          c_i,
    output logic [W-1:0]  res_o,
    output logic          c_o
);
    localparam int SW = $clog2(W + 2);
    localparam int RW = $clog2(W);

    logic [SW-1:0]       sat_log;
    logic [SW-1:0]       sat_ari;
    logic [RW-1:0]       rot;
    logic [W:0]          lsl_w;
    logic [W:0]          lsr_w;
    logic signed [W:0]   asr_w;
    logic [2*W-1:0]      ror_w;

    always_comb begin
        sat_log = (int'(amt_i) > W)  ? SW'(W + 1) : SW'(amt_i);
        sat_ari = (int'(amt_i) >= W) ? SW'(W)     : SW'(amt_i);
        rot     = amt_i[RW-1:0];
        lsl_w   = {1'b0, opd_i} << sat_log;
        lsr_w   = {opd_i, 1'b0} >> sat_log;
        asr_w   = $signed({opd_i, 1'b0}) >>> sat_ari;
        ror_w   = {opd_i, opd_i} >> rot;
    end

    always_comb begin
        res_o = opd_i;
        c_o   = c_i;
        if (amt_i != '0) begin
            unique case (op_i)
                MV_LSL: begin
                    res_o = lsl_w[W-1:0];
                    c_o   = lsl_w[W];
                end
                MV_LSR: begin
                    res_o = lsr_w[W:1];
                    c_o   = lsr_w[0];
                end
                MV_ASR: begin
                    res_o = asr_w[W:1];
                    c_o   = asr_w[0];
                end
                MV_ROR: begin
                    res_o = ror_w[W-1:0];
                    c_o   = (rot == '0) ? opd_i[W-1] : ror_w[W-1];
                end
                default: begin
                    res_o = opd_i;
                    c_o   = c_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
    import shf_pkg::*;
#(
    parameter int W       = 32,
    parameter int IW      = $clog2(W),
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  opd_i,
    input  logic [IW-1:0] imm_i,
    input  logic [W-1:0]  rs_i,
    input  logic          src_reg_i,
    input  logic [1:0]    op_i,
    input  logic [3:0]    flags_i,
    output logic [W-1:0]  res_o,
    output logic [3:0]    flags_o
);
    localparam int AW = 8;

    shf_op_e        op_e;
    shf_flags_t     fin;
    shf_flags_t     fnext;
    logic [AW-1:0]  amt;
    logic [W-1:0]   res_next;
    logic           c_next;

    assign op_e = shf_op_e'(op_i);
    assign fin  = shf_flags_t'(flags_i);

    shf_amount #(.W(W), .IW(IW), .AW(AW)) u_amt (
        .imm_i     (imm_i),
        .rs_i      (rs_i),
        .src_reg_i (src_reg_i),
        .op_i      (op_e),
        .amt_o     (amt)
    );

    shf_core #(.W(W), .AW(AW)) u_core (
        .opd_i (opd_i),
        .amt_i (amt),
        .op_i  (op_e),
        .c_i   (fin.c),
        .res_o (res_next),
        .c_o   (c_next)
    );

    always_comb begin
        fnext.n = res_next[W-1];
        fnext.z = (res_next == '0);
        fnext.c = c_next;
        fnext.v = fin.v;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_o   <= '0;
                    flags_o <= '0;
                end else begin
                    res_o   <= res_next;
                    flags_o <= fnext;
                end
            end
        end else begin : g_comb
            assign res_o   = res_next;
            assign flags_o = fnext;
        end
    endgenerate
endmodule

// File: rtl/shifter_unit_chk.sv
module shifter_unit_chk #(
    parameter int W       = 32,
    parameter int IW      = $clog2(W),
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  opd_i,
    input logic [IW-1:0] imm_i,
    input logic [W-1:0]  rs_i,
    input logic          src_reg_i,
    input logic [1:0]    op_i,
    input logic [3:0]    flags_i,
    input logic [W-1:0]  res_o,
    input logic [3:0]    flags_o
);
    logic armed;
    logic zero_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign zero_len = src_reg_i ? (rs_i[7:0] == 8'd0)
                                : (imm_i == '0 && (op_i == 2'd1 || op_i == 2'd3));

    generate
        if (REG_OUT) begin : g_chk
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> (res_o == '0 && flags_o == 4'd0)); // R12

            AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                flags_o[3] == res_o[W-1]); // R4

            AST_Z_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                flags_o[2] == (res_o == '0)); // R4

            AST_V_PASS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                flags_o[0] == $past(flags_i[0])); // R5

            AST_ZERO_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                $past(zero_len) |-> (res_o == $past(opd_i) && flags_o[1] == $past(flags_i[1]))); // R6

            AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                ($past(op_i) == 2'd3 && !$past(zero_len)) |-> flags_o[1] == res_o[W-1]); // R11
        end
    endgenerate
endmodule

bind shifter_unit shifter_unit_chk #(.W(W), .IW(IW), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opd_i     (opd_i),
    .imm_i     (imm_i),
    .rs_i      (rs_i),
    .src_reg_i (src_reg_i),
    .op_i      (op_i),
    .flags_i   (flags_i),
    .res_o     (res_o),
    .flags_o   (flags_o)
);

// File: tb/shifter_unit_test.sv
module shifter_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opd = '0;
    logic [4:0]  imm = '0;
    logic [31:0] rs = '0;
    logic        src = 1'b0;
    logic [1:0]  op = '0;
    logic [3:0]  fin = '0;
    logic [31:0] res;
    logic [3:0]  fout;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shifter_unit uut (
        .clk(clk), .rst_n(rst_n), .opd_i(opd), .imm_i(imm), .rs_i(rs),
        .src_reg_i(src), .op_i(op), .flags_i(fin), .res_o(res), .flags_o(fout)
    );

    // Reference: step one place at a time for the effective length.
    function automatic logic [35:0] model(input logic [31:0] a, input logic [4:0] im,
                                          input logic [31:0] r, input logic s,
                                          input logic [1:0] k, input logic [3:0] f);
        int n;
        logic [31:0] v;
        logic c;
        if (s) n = int'(r[7:0]);
        else if (im == 0 && (k == 2'd0 || k == 2'd2)) n = 32;
        else n = int'(im);
        v = a;
        c = f[1];
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin c = v[0];  v = {v[31], v[31:1]}; end
                2'd1: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'd2: begin c = v[0];  v = {1'b0, v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {v, v[31], (v == 0), c, f[0]};
    endfunction

    task automatic apply_check(input logic [31:0] a, input logic [4:0] im,
                               input logic [31:0] r, input logic s,
                               input logic [1:0] k, input logic [3:0] f,
                               input string tag);
        logic [35:0] exp;
        opd = a; imm = im; rs = r; src = s; op = k; fin = f;
        exp = model(a, im, r, s, k, f);
        @(negedge clk);
        tests++;
        if ({res, fout} !== exp) begin
            fails++;
            $display("FAIL %s op=%0d src=%0d: got res=%h fl=%b, expected res=%h fl=%b",
                     tag, k, s, res, fout, exp[35:4], exp[3:0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        opd = 32'hDEAD_BEEF; fin = 4'hF;
        repeat (3) @(negedge clk);
        tests++;
        if (res !== '0 || fout !== 4'd0) begin
            fails++;
            $display("FAIL R12: got res=%h fl=%b, expected 0 0", res, fout);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: immediate encodings
        apply_check(32'h8000_0001, 5'd0, '0, 1'b0, 2'd0, 4'b0000, "R2 asr imm0=32");
        apply_check(32'h8000_0001, 5'd0, '0, 1'b0, 2'd2, 4'b0000, "R2 lsr imm0=32");
        apply_check(32'h1234_5678, 5'd0, '0, 1'b0, 2'd1, 4'b0011, "R6 lsl imm0 move");
        apply_check(32'h1234_5678, 5'd0, '0, 1'b0, 2'd3, 4'b0010, "R6 ror imm0");
        apply_check(32'hF000_000F, 5'd9, '0, 1'b0, 2'd0, 4'b0000, "R1 asr imm9");
        apply_check(32'h8000_0003, 5'd3, '0, 1'b0, 2'd1, 4'b0000, "R7 lsl imm3");
        apply_check(32'h0000_0060, 5'd6, '0, 1'b0, 2'd2, 4'b0000, "R7 lsr imm6");
        // R3: upper register bits ignored
        apply_check(32'hCAFE_F00D, 5'd7, 32'hFFFF_FF04, 1'b1, 2'd2, 4'b0000, "R3 upper bits");
        apply_check(32'hCAFE_F00D, 5'd7, 32'hABCD_EF00, 1'b1, 2'd1, 4'b0010, "R6 reg len 0");
        // boundaries per move kind
        for (int k = 0; k < 4; k++) begin
            apply_check(32'h8000_0001, 5'd0, 32'd1,   1'b1, 2'(k), 4'b0000, "R7 len1");
            apply_check(32'h8000_0001, 5'd0, 32'd31,  1'b1, 2'(k), 4'b0000, "R7 len31");
            apply_check(32'h8000_0001, 5'd0, 32'd32,  1'b1, 2'(k), 4'b0010, "R8 R10 R11 len32");
            apply_check(32'h7FFF_FFFE, 5'd0, 32'd32,  1'b1, 2'(k), 4'b0010, "R8 R10 R11 len32b");
            apply_check(32'hFFFF_FFFF, 5'd0, 32'd33,  1'b1, 2'(k), 4'b0010, "R9 R10 R11 len33");
            apply_check(32'h8000_0001, 5'd0, 32'd255, 1'b1, 2'(k), 4'b0011, "R9 R10 len255");
            apply_check(32'h8000_0001, 5'd0, 32'd64,  1'b1, 2'(k), 4'b0000, "R11 len64");
            apply_check(32'h0000_0000, 5'd4, 32'd0,   1'b0, 2'(k), 4'b0001, "R4 R5 zero");
        end
        // random mix
        for (int i = 0; i < 3000; i++) begin
            apply_check($urandom, 5'($urandom), ($urandom & 32'hFFFF_FF3F) | 32'(($urandom % 3) << 6),
                        1'($urandom), 2'($urandom), 4'($urandom), "R1 R4 R5 R7 random");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule